// File: doc/BRIEF.md
# Virtual Scan Chain Hub

This block lets several user scan nodes share one test access port. The host reaches them through two user data-register instructions of the device instruction register. Code `0x00E` opens the instruction path and code `0x00C` opens the data path. The hub runs its own copy of the TAP state machine from TCK and TMS, so it always knows which TAP state a scan is in.

During an instruction-path scan the hub shifts a word made of a node address and a virtual instruction value. On the update step, the addressed node latches that value. During a data-path scan the hub sends one-hot virtual state strobes to the node that was last addressed and passes that node's TDO back out.

Address 0 is the hub itself. The hub's own 4-bit virtual instruction can select an enumeration readout, which describes the hub and every node. It can also arm a command that re-points which node's virtual instruction is captured on the next instruction-path scan.

Top module: `vscan_hub`

## Requirements
- R1: A synchronous `hub_rst`, or five TCK rising edges in a row with TMS high, brings the hub to Test-Logic-Reset. In that state every node VIR is 0, the active and capture addresses are 0, the hub VIR is 0, and `vstrobe` and `vsel` are 0.
- R2: The mirrored state machine follows the standard TAP transitions. During data-path scans to a node, `vstrobe` is one-hot with bit 0 = capture-DR, 1 = shift-DR, 2 = exit1-DR, 3 = pause-DR, 4 = exit2-DR and 5 = update-DR.
- R3: When `dev_ir` is `0x00E`, every TAP data scan goes through an NA+VW bit word, with NA = clog2(N+1) and VW = the larger of 4 and the widest node VIR. Bits enter on `tdi` and leave on `tdo` least significant bit first. ADDR is the upper NA bits and the VIR value is the lower VW bits.
- R4: An instruction-path Update-DR with ADDR k in 1..N stores the VIR value, masked to node k's width, in `vir_flat[(k-1)*VW +: VW]`. The unused upper bits of that slot stay 0 and every other node keeps its VIR. An ADDR above N stores nothing.
- R5: An instruction-path Capture-DR loads {capture address, VIR of that address}. The capture address is the ADDR of the last normal update. Address 0 yields the hub VIR, zero-extended, and an address above N yields 0.
- R6: An update with ADDR 0 and a low VIR nibble of 3 arms the re-point command. The next instruction-path update then only does four things: it sets the capture address to its ADDR, latches no node VIR, raises no update-IR strobe and clears the hub VIR to 0. The active address stays as it was.
- R7: When `dev_ir` is `0x00C` and the active address k is in 1..N, the data-register strobes go to node k (`vsel` bit k-1 alone) and `tdo` equals `node_tdo[k-1]`.
- R8: During instruction-path scans, `vstrobe` bit 6 (capture-IR) is high in Capture-DR when the capture address is a node, and `vsel` then marks that node. Bit 7 (update-IR) is high in Update-DR for a normal update whose ADDR is a node, and `vsel` then marks that ADDR.
- R9: With active address 0 and hub VIR 0, each data-path scan is 4 bits long. Each Capture-DR loads the next nibble, low nibble first, and the nibble pointer advances on each Update-DR. The readout gives the configuration word, then one word per node in node order, then starts over. Any write of the hub VIR (including the clear in R6) restarts it at the configuration word.
- R10: The configuration word is {version[31:27], N[26:19], 0x06E[18:8], VW[7:0]}. A node word is {version[31:27], type 8[26:19], 0x06E[18:8], instance id[7:0]}.
- R11: On the data path with active address 0 and a non-zero hub VIR, or with an active address above N, the chain is a 1-bit register that captures 0. In that case no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock, clocks all hub state |
| hub_rst | input | 1 | Device-wide synchronous reset of the hub, active high |
| tms | input | 1 | Test mode select, drives the mirrored state machine |
| tdi | input | 1 | Serial data in |
| dev_ir | input | 10 | Current device instruction register value |
| node_tdo | input | NODES | Serial data out of each node's data chain |
| tdo | output | 1 | Serial data out of the hub |
| vstrobe | output | 8 | One-hot virtual state strobe |
| vsel | output | NODES | One-hot node that the strobe is meant for |
| vir_flat | output | NODES*VW | Latched VIR of every node, VW bits per node |

## Verification
Several properties are checked on every cycle:
- The strobe vector is never more than one-hot, and any strobe has exactly one target node.
- A node VIR changes only on an update addressed to that node.
- Five TMS-high edges always land in Test-Logic-Reset.
- The enumeration pointer moves only on advance or rewind and stays in range.

Some behaviour only the bench scenarios can show. This covers the scan word contents, masking and padding of VIRs, re-pointing of the capture path, nibble ordering of the enumeration words and their wrap, and the bypass delay. The bench mixes random addresses and values with directed scans through pause states, invalid addresses and both reset routes.

// File: rtl/vhub_pkg.sv
package vhub_pkg;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_st_e;

    localparam logic [9:0]  OP_VIR_PATH    = 10'h00E;
    localparam logic [9:0]  OP_VDR_PATH    = 10'h00C;
    localparam logic [10:0] MFR_CODE       = 11'h06E;
    localparam logic [7:0]  GENERIC_KIND   = 8'd8;
    localparam int unsigned HUB_VIR_W      = 4;
    localparam logic [3:0]  HUB_OP_INFO    = 4'd0;
    localparam logic [3:0]  HUB_OP_REPOINT = 4'd3;

    localparam int STB_CDR = 0;
    localparam int STB_SDR = 1;
    localparam int STB_E1D = 2;
    localparam int STB_PDR = 3;
    localparam int STB_E2D = 4;
    localparam int STB_UDR = 5;
    localparam int STB_CIR = 6;
    localparam int STB_UIR = 7;

    typedef struct packed {
        logic [4:0]  ver;
        logic [7:0]  kind;
        logic [10:0] mfr;
        logic [7:0]  tail;
    } info_word_t;

    function automatic int unsigned vir_field_w(input logic [255:0] lst, input int unsigned n);
        int unsigned r = HUB_VIR_W;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < n && 32'(lst[i*8 +: 8]) > r) r = 32'(lst[i*8 +: 8]);
        end
        return r;
    endfunction

    function automatic int unsigned addr_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction

    function automatic logic addr_is_node(input logic [7:0] a, input int unsigned n);
        return (a != 8'd0) && (32'(a) <= n);
    endfunction

    function automatic tap_st_e tap_next(input tap_st_e s, input logic tms);
        case (s)
            TLR:     return tms ? TLR    : RTI;
            RTI:     return tms ? SEL_DR : RTI;
            SEL_DR:  return tms ? SEL_IR : CAP_DR;
            CAP_DR:  return tms ? EX1_DR : SH_DR;
            SH_DR:   return tms ? EX1_DR : SH_DR;
            EX1_DR:  return tms ? UPD_DR : PAU_DR;
            PAU_DR:  return tms ? EX2_DR : PAU_DR;
            EX2_DR:  return tms ? UPD_DR : SH_DR;
            UPD_DR:  return tms ? SEL_DR : RTI;
            SEL_IR:  return tms ? TLR    : CAP_IR;
            CAP_IR:  return tms ? EX1_IR : SH_IR;
            SH_IR:   return tms ? EX1_IR : SH_IR;
            EX1_IR:  return tms ? UPD_IR : PAU_IR;
            PAU_IR:  return tms ? EX2_IR : PAU_IR;
            EX2_IR:  return tms ? UPD_IR : SH_IR;
            UPD_IR:  return tms ? SEL_DR : RTI;
            default: return TLR;
        endcase
    endfunction

    function automatic logic [7:0] dr_strobe(input tap_st_e s);
        logic [7:0] v = '0;
        case (s)
            CAP_DR:  v[STB_CDR] = 1'b1;
            SH_DR:   v[STB_SDR] = 1'b1;
            EX1_DR:  v[STB_E1D] = 1'b1;
            PAU_DR:  v[STB_PDR] = 1'b1;
            EX2_DR:  v[STB_E2D] = 1'b1;
            UPD_DR:  v[STB_UDR] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/vhub_tap_mirror.sv
module vhub_tap_mirror
    import vhub_pkg::*;
(
    input  logic    tck,
    input  logic    rst,
    input  logic    tms,
    output tap_st_e st_o
);

    always_ff @(posedge tck) begin
        if (rst) st_o <= TLR;
        else     st_o <= tap_next(st_o, tms);
    end

    // run length of TMS-high edges, saturating at five
    logic [2:0] hi_run;
    always_ff @(posedge tck) begin
        if (rst || !tms)          hi_run <= 3'd0;
        else if (hi_run != 3'd5)  hi_run <= hi_run + 3'd1;
    end

    // R1
    tlr_after_five_chk: assert property (@(posedge tck) disable iff (rst)
        (hi_run == 3'd5) |-> (st_o == TLR));

endmodule

// File: rtl/vhub_vir_bank.sv
module vhub_vir_bank #(
    parameter int unsigned NODES    = 2,
    parameter int unsigned VW       = 4,
    parameter int unsigned NA       = 2,
    parameter logic [NODES*8-1:0] IRW_LIST = '0
) (
    input  logic                tck,
    input  logic                clr,
    input  logic                upd_en,
    input  logic [NA-1:0]       upd_addr,
    input  logic [VW-1:0]       upd_val,
    output logic [NODES*VW-1:0] vir_flat_o
);

    for (genvar i = 0; i < NODES; i++) begin : g_node
        localparam int unsigned NW = 32'(IRW_LIST[i*8 +: 8]);
        localparam logic [VW-1:0] KEEP = VW'((64'(1) << NW) - 64'(1));
        logic [VW-1:0] q;
        logic hit;
        assign hit = upd_en && (32'(upd_addr) == i + 1);

        always_ff @(posedge tck) begin
            if (clr)      q <= '0;
            else if (hit) q <= upd_val & KEEP;
        end
        assign vir_flat_o[i*VW +: VW] = q;

        // R4
        stable_vir_chk: assert property (@(posedge tck) disable iff (clr)
            !(upd_en && (32'(upd_addr) == i + 1)) |=> $stable(vir_flat_o[i*VW +: VW]));
    end

endmodule

// File: rtl/vhub_info.sv
module vhub_info
    import vhub_pkg::*;
#(
    parameter int unsigned NODES   = 2,
    parameter int unsigned VW      = 4,
    parameter int unsigned VERSION = 1,
    parameter logic [NODES*8-1:0] ID_LIST = '0
) (
    input  logic       tck,
    input  logic       clr,
    input  logic       rewind,
    input  logic       advance,
    output logic [3:0] nib_o
);

    localparam int unsigned TOTAL = (NODES + 1) * 8;
    localparam int unsigned PTR_W = $clog2(TOTAL);

    logic [PTR_W-1:0] ptr;
    info_word_t       word;

    always_ff @(posedge tck) begin
        if (clr || rewind)                    ptr <= '0;
        else if (advance) begin
            if (32'(ptr) == TOTAL - 1)        ptr <= '0;
            else                              ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        word = '{ver: 5'(VERSION), kind: 8'(NODES), mfr: MFR_CODE, tail: 8'(VW)};
        for (int k = 0; k < NODES; k++) begin
            if (32'(ptr[PTR_W-1:3]) == k + 1)
                word = '{ver: 5'(VERSION), kind: GENERIC_KIND, mfr: MFR_CODE,
                         tail: ID_LIST[k*8 +: 8]};
        end
    end

    assign nib_o = word[ptr[2:0]*4 +: 4];

    // R9
    ptr_range_chk: assert property (@(posedge tck) disable iff (clr)
        32'(ptr) < TOTAL);

    // R9
    ptr_hold_chk: assert property (@(posedge tck) disable iff (clr)
        !(advance || rewind) |=> $stable(ptr));

endmodule

// File: rtl/vscan_hub.sv
module vscan_hub
    import vhub_pkg::*;
#(
    parameter int unsigned NODES = 2,
    parameter logic [NODES*8-1:0] IRW_LIST = 16'h0603,
    parameter logic [NODES*8-1:0] ID_LIST  = 16'h0904,
    parameter int unsigned VERSION = 1,
    localparam int unsigned VW = vir_field_w(256'(IRW_LIST), NODES),
    localparam int unsigned NA = addr_w(NODES)
) (
    input  logic                tck,
    input  logic                hub_rst,
    input  logic                tms,
    input  logic                tdi,
    input  logic [9:0]          dev_ir,
    input  logic [NODES-1:0]    node_tdo,
    output logic                tdo,
    output logic [7:0]          vstrobe,
    output logic [NODES-1:0]    vsel,
    output logic [NODES*VW-1:0] vir_flat
);

    localparam int unsigned SW = NA + VW;

    tap_st_e st;
    logic clr, in_vir, in_vdr;
    logic [SW-1:0] sr;
    logic [3:0]    dsr;
    logic [3:0]    hub_vir;
    logic [NA-1:0] act, cap, tgt;
    logic [NA-1:0] sr_addr;
    logic [VW-1:0] sr_val, cap_vir;
    logic upd_ir_ev, repoint, normal_upd, node_upd, hub_upd;
    logic act_ok, cap_ok, addr_ok, info_mode, info_adv;
    logic [3:0] info_nib;
    logic sel_tdo;

    vhub_tap_mirror u_tap (.tck(tck), .rst(hub_rst), .tms(tms), .st_o(st));

    assign clr     = hub_rst || (st == TLR);
    assign in_vir  = (dev_ir == OP_VIR_PATH);
    assign in_vdr  = (dev_ir == OP_VDR_PATH);
    assign sr_addr = sr[SW-1 -: NA];
    assign sr_val  = sr[VW-1:0];

    assign upd_ir_ev  = in_vir && (st == UPD_DR);
    assign repoint    = upd_ir_ev && (hub_vir == HUB_OP_REPOINT);
    assign normal_upd = upd_ir_ev && !repoint;
    assign addr_ok    = addr_is_node(8'(sr_addr), NODES);
    assign node_upd   = normal_upd && addr_ok;
    assign hub_upd    = normal_upd && (sr_addr == '0);
    assign act_ok     = addr_is_node(8'(act), NODES);
    assign cap_ok     = addr_is_node(8'(cap), NODES);
    assign info_mode  = (act == '0) && (hub_vir == HUB_OP_INFO);
    assign info_adv   = in_vdr && (st == UPD_DR) && info_mode;

    vhub_vir_bank #(.NODES(NODES), .VW(VW), .NA(NA), .IRW_LIST(IRW_LIST)) u_bank (
        .tck(tck), .clr(clr), .upd_en(node_upd), .upd_addr(sr_addr),
        .upd_val(sr_val), .vir_flat_o(vir_flat)
    );

    vhub_info #(.NODES(NODES), .VW(VW), .VERSION(VERSION), .ID_LIST(ID_LIST)) u_info (
        .tck(tck), .clr(clr), .rewind(hub_upd || repoint),
        .advance(info_adv), .nib_o(info_nib)
    );

    // capture-path VIR and node TDO select
    always_comb begin
        cap_vir = (cap == '0) ? VW'(hub_vir) : '0;
        sel_tdo = 1'b0;
        for (int k = 0; k < NODES; k++) begin
            if (32'(cap) == k + 1) cap_vir = vir_flat[k*VW +: VW];
            if (32'(act) == k + 1) sel_tdo = node_tdo[k];
        end
    end

    always_ff @(posedge tck) begin
        if (clr) begin
            sr      <= '0;
            dsr     <= '0;
            hub_vir <= '0;
            act     <= '0;
            cap     <= '0;
        end else begin
            if (in_vir) begin
                case (st)
                    CAP_DR: sr <= {cap, cap_vir};
                    SH_DR:  sr <= {tdi, sr[SW-1:1]};
                    UPD_DR: begin
                        cap <= sr_addr;
                        if (repoint) begin
                            hub_vir <= '0;
                        end else begin
                            act <= sr_addr;
                            if (sr_addr == '0) hub_vir <= sr_val[3:0];
                        end
                    end
                    default: ;
                endcase
            end
            if (in_vdr && !act_ok) begin
                case (st)
                    CAP_DR: dsr <= info_mode ? info_nib : 4'd0;
                    SH_DR:  dsr <= info_mode ? {tdi, dsr[3:1]} : {3'b000, tdi};
                    default: ;
                endcase
            end
        end
    end

    // strobe generation
    always_comb begin
        vstrobe = '0;
        tgt     = '0;
        if (in_vdr && act_ok) begin
            vstrobe = dr_strobe(st);
            tgt     = act;
        end else if (in_vir && st == CAP_DR && cap_ok) begin
            vstrobe[STB_CIR] = 1'b1;
            tgt              = cap;
        end else if (in_vir && st == UPD_DR && !repoint && addr_ok) begin
            vstrobe[STB_UIR] = 1'b1;
            tgt              = sr_addr;
        end
        for (int k = 0; k < NODES; k++)
            vsel[k] = (vstrobe != '0) && (32'(tgt) == k + 1);
    end

    assign tdo = in_vdr ? (act_ok ? sel_tdo : dsr[0]) : sr[0];

    // R2
    strobe_onehot_chk: assert property (@(posedge tck) disable iff (hub_rst)
        $onehot0(vstrobe));

    // R7
    strobe_target_chk: assert property (@(posedge tck) disable iff (hub_rst)
        (vstrobe != '0) |-> ($countones(vsel) == 1));

    // R11
    no_target_quiet_chk: assert property (@(posedge tck) disable iff (hub_rst)
        (vstrobe == '0) |-> (vsel == '0));

endmodule

// File: tb/vscan_hub_tb_top.sv
module vscan_hub_tb_top;

    localparam int N  = 2;
    localparam int VW = 6;
    localparam int SW = 8;
    localparam logic [9:0] USER1 = 10'h00E;
    localparam logic [9:0] USER0 = 10'h00C;

    logic clk = 1'b0;
    logic rst, tms, tdi;
    logic [9:0] dev_ir;
    logic [N-1:0] ntdo;
    logic tdo;
    logic [7:0] vst;
    logic [N-1:0] vsel;
    logic [N*VW-1:0] vflat;

    always #5 clk = ~clk;

    vscan_hub dut_i (
        .tck(clk), .hub_rst(rst), .tms(tms), .tdi(tdi), .dev_ir(dev_ir),
        .node_tdo(ntdo), .tdo(tdo), .vstrobe(vst), .vsel(vsel), .vir_flat(vflat)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [VW-1:0] m_vir [N];
    logic [3:0]    m_hub;
    logic [1:0]    m_act, m_cap;
    logic [7:0]    cap_vst, sh_vst, upd_vst;
    logic [N-1:0]  cap_sel, sh_sel, upd_sel;

    task automatic check(input string r, input logic [63:0] a, input logic [63:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, a, e);
        end
    endtask

    task automatic step(input logic t, input logic d);
        @(negedge clk);
        tms = t;
        tdi = d;
        @(posedge clk);
        #2;
    endtask

    task automatic scan(input int len, input logic [63:0] din, output logic [63:0] dout);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        cap_vst = vst; cap_sel = vsel;
        step(1'b0, 1'b0);
        sh_vst = vst; sh_sel = vsel;
        dout = '0;
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            step(i == len - 1, din[i]);
        end
        step(1'b1, 1'b0);
        upd_vst = vst; upd_sel = vsel;
        step(1'b0, 1'b0);
    endtask

    function automatic logic [VW-1:0] keep(input int k);
        return (k == 0) ? 6'h07 : 6'h3F;
    endfunction

    function automatic logic [VW-1:0] vir_of(input logic [1:0] a);
        if (a == 2'd0) return VW'(m_hub);
        if (a <= 2'd2) return m_vir[a - 1];
        return '0;
    endfunction

    function automatic logic [N-1:0] onehot(input logic [1:0] a);
        return (a == 2'd1) ? 2'b01 : (a == 2'd2) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [N*VW-1:0] model_flat();
        return {m_vir[1], m_vir[0]};
    endfunction

    task automatic model_clear();
        m_vir[0] = '0; m_vir[1] = '0; m_hub = '0; m_act = '0; m_cap = '0;
    endtask

    // instruction-path scan: checks captured word, strobes, then updates model
    task automatic ir_write(input logic [1:0] addr, input logic [VW-1:0] val, input string r);
        logic [63:0] d;
        logic armed;
        dev_ir = USER1;
        scan(SW, 64'({addr, val}), d);
        check({r, " R5 capture word"}, d[SW-1:0], {m_cap, vir_of(m_cap)});
        check("R8 capture-IR strobe", {cap_vst, 6'b0, cap_sel},
              {(m_cap inside {2'd1, 2'd2}) ? 8'h40 : 8'h00, 6'b0, onehot(m_cap)});
        armed = (m_hub == 4'd3);
        check("R8 update-IR strobe", {upd_vst, 6'b0, upd_sel},
              {(!armed && addr inside {2'd1, 2'd2}) ? 8'h80 : 8'h00, 6'b0,
               armed ? 2'b00 : onehot(addr)});
        if (armed) begin
            m_cap = addr;
            m_hub = 4'd0;
        end else begin
            m_act = addr;
            m_cap = addr;
            if (addr == 2'd0) m_hub = val[3:0];
            else if (addr <= 2'd2) m_vir[addr - 1] = val & keep(addr - 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [31:0] w;
        logic [31:0] exp_w [3];
        void'($urandom(32'h5EED));
        exp_w[0] = {5'd1, 8'd2, 11'h06E, 8'd6};
        exp_w[1] = {5'd1, 8'd8, 11'h06E, 8'h04};
        exp_w[2] = {5'd1, 8'd8, 11'h06E, 8'h09};
        rst = 1'b1; tms = 1'b1; tdi = 1'b0; dev_ir = '0; ntdo = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 reset vir", 64'(vflat), 64'(0));
        check("R1 reset strobes", {vst, 6'b0, vsel}, 16'h0);
        step(1'b0, 1'b0);

        // R4 masking, padding and invalid address (R3 word format)
        ir_write(2'd1, 6'h3D, "R3");
        check("R4 node0 masked", 64'(vflat), 64'(model_flat()));
        ir_write(2'd2, 6'h2A, "R3");
        check("R4 node1 full", 64'(vflat), 64'(model_flat()));
        ir_write(2'd3, 6'h11, "R4");
        check("R4 invalid addr ignored", 64'(vflat), 64'(model_flat()));

        // constrained random instruction scans
        for (int it = 0; it < 40; it++) begin
            ir_write(2'($urandom % 4), 6'($urandom % 64), "R5");
            check("R4 random vir", 64'(vflat), 64'(model_flat()));
        end

        // R6 re-point
        ir_write(2'd1, 6'h05, "R6");
        ir_write(2'd2, 6'h21, "R6");
        ir_write(2'd0, 6'h03, "R6");
        ir_write(2'd1, 6'h3F, "R6");
        check("R6 no vir latched", 64'(vflat), 64'(model_flat()));
        ir_write(2'd1, 6'h02, "R6 repointed");

        // R7 data path to node 1 and strobes (R2)
        dev_ir = USER0; ntdo = 2'b01;
        scan(8, 64'hA5, d);
        check("R7 tdo node1 high", d[7:0], 8'hFF);
        check("R2 capture strobe", {cap_vst, 6'b0, cap_sel}, {8'h01, 8'h01});
        check("R2 shift strobe", {sh_vst, 6'b0, sh_sel}, {8'h02, 8'h01});
        check("R2 update strobe", {upd_vst, 6'b0, upd_sel}, {8'h20, 8'h01});
        ntdo = 2'b10;
        scan(8, 64'h5A, d);
        check("R7 tdo node1 low", d[7:0], 8'h00);
        // R2 pause path
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check("R2 exit1 strobe", vst, 8'h04);
        step(1'b0, 1'b0);
        check("R2 pause strobe", vst, 8'h08);
        step(1'b1, 1'b0);
        check("R2 exit2 strobe", vst, 8'h10);
        step(1'b0, 1'b0);
        check("R2 back to shift", vst, 8'h02);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R2 update after pause", {vst, 6'b0, vsel}, {8'h20, 8'h01});
        step(1'b0, 1'b0);
        ir_write(2'd2, 6'h00, "R7");
        dev_ir = USER0;
        scan(8, 64'h33, d);
        check("R7 tdo node2", d[7:0], 8'hFF);
        check("R7 select node2", {sh_vst, 6'b0, sh_sel}, {8'h02, 8'h02});

        // R11 bypass
        ir_write(2'd3, 6'h00, "R11");
        dev_ir = USER0;
        scan(8, 64'hB4, d);
        check("R11 bypass invalid addr", d[7:0], 8'h68);
        check("R11 no strobe", {cap_vst, sh_vst, upd_vst}, 24'h0);
        ir_write(2'd0, 6'h05, "R11");
        dev_ir = USER0;
        scan(8, 64'hC3, d);
        check("R11 bypass hub vir", d[7:0], 8'h86);

        // R9 / R10 enumeration
        ir_write(2'd0, 6'h00, "R9");
        dev_ir = USER0;
        for (int wi = 0; wi < 3; wi++) begin
            w = '0;
            for (int j = 0; j < 8; j++) begin
                scan(4, 64'h0, d);
                w[j*4 +: 4] = d[3:0];
            end
            check((wi == 0) ? "R10 config word" : "R10 node word", 64'(w), 64'(exp_w[wi]));
        end
        scan(4, 64'h0, d);
        check("R9 wrap to config", d[3:0], exp_w[0][3:0]);
        scan(4, 64'h0, d);
        scan(4, 64'h0, d);
        check("R9 third nibble", d[3:0], exp_w[0][11:8]);
        ir_write(2'd0, 6'h00, "R9");
        dev_ir = USER0;
        scan(4, 64'h0, d);
        check("R9 rewind on hub write", d[3:0], exp_w[0][3:0]);

        // R1 five TMS-high edges
        ir_write(2'd1, 6'h07, "R1");
        ir_write(2'd2, 6'h15, "R1");
        repeat (5) step(1'b1, 1'b0);
        check("R1 tlr clears vir", 64'(vflat), 64'(0));
        model_clear();
        step(1'b0, 1'b0);
        ir_write(2'd1, 6'h04, "R1 after tlr");

        // R1 synchronous hub reset
        ir_write(2'd2, 6'h09, "R1");
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #2;
        check("R1 hub_rst clears vir", 64'(vflat), 64'(0));
        @(negedge clk) rst = 1'b0;
        model_clear();
        step(1'b0, 1'b0);
        ir_write(2'd2, 6'h01, "R1 after rst");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule